// File: doc/BRIEF.md
# Transfer Ring Doorbell Consumer

This block is the device-side engine that works through host-written circular work queues, one per unidirectional channel. Each channel keeps a context of ring base address, ring size, read index and write index. The host publishes work by writing ring elements into its memory and then ringing the channel doorbell. The doorbell carries the new write index. The engine picks a channel that has work, fetches elements one at a time over a request/response memory-read interface, and advances the channel read index after each element. It follows chained elements until it reaches the last element of a descriptor. It then offers one completion record to a downstream event producer.

All three data interfaces use valid/ready. On the fetch request channel the engine raises `rd_req_valid` with a stable `rd_req_addr` and holds both until `rd_req_ready`. At most one fetch is outstanding. `rd_rsp_ready` is high only while a response is awaited, so responses may be stalled by the engine as long as needed. A completion is held with stable fields until `cpl_ready` is high. Configuration and doorbell inputs are single-cycle strobes with no back-pressure.

Top module: `tdc_ring_consumer`

## Requirements
- R1: After reset, `rd_req_valid`, `rd_rsp_ready` and `cpl_valid` are low, and every ring is empty.
- R2: A configuration strobe on a channel loads its base address and its size (element count, at least 2) and sets its read and write indices to 0, so the ring is empty and no fetch follows.
- R3: A doorbell that sets the write index to a value different from the read index makes the channel pending. Each fetch address equals base + read_index*16.
- R4: A doorbell whose new write index equals the channel read index is ignored: no fetch and no completion result from it.
- R5: Indices wrap to 0 after size-1. A ring holding size-1 elements (write index one behind the read index) has all of them fetched in order.
- R6: Each element is 128 bits: bits [63:0] buffer address, [79:64] length, [95:80] control. Control bit 0 (element bit 80) set means another element of the same descriptor follows; clear marks the last element.
- R7: Exactly one completion is produced per descriptor. It carries the channel, the number of elements, the sum of the element lengths and the read index after the descriptor.
- R8: Pending channels are served round-robin, starting with the channel after the one served last (channel 0 first after reset). A descriptor completes before another channel is started.
- R9: If a chained element is the last one written, the engine waits on that channel with no fetch request until a doorbell extends the ring, then continues the same descriptor.
- R10: `rd_req_valid` with `rd_req_addr` and `cpl_valid` with its fields stay stable until accepted.
- R11: At most one fetch is outstanding. `rd_rsp_ready` is never high while `rd_req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration strobe |
| cfg_ch | input | CHW | Channel being configured |
| cfg_base | input | AW | Ring base byte address |
| cfg_size | input | IW | Ring size in elements |
| db_valid | input | 1 | Doorbell strobe |
| db_ch | input | CHW | Doorbell channel |
| db_wp | input | IW | New write index |
| rd_req_valid | output | 1 | Fetch request valid |
| rd_req_ready | input | 1 | Fetch request accepted |
| rd_req_addr | output | AW | Element byte address |
| rd_rsp_valid | input | 1 | Fetch response valid |
| rd_rsp_ready | output | 1 | Engine accepts response |
| rd_rsp_data | input | 128 | Fetched element |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion accepted |
| cpl_ch | output | CHW | Completed channel |
| cpl_elems | output | IW | Elements in descriptor |
| cpl_bytes | output | 16+IW | Sum of element lengths |
| cpl_next_rp | output | IW | Read index after descriptor |

## Verification
The hardest situation to reach from the ports is a descriptor whose chain runs past the written part of the ring. This is combined with a full ring that wraps its indices. The bench reaches the first case by marking the element just before the write index as chained, holding the engine idle on that channel for a window, and then ringing a second doorbell. It reaches the second by advancing the write index to one behind the read index on the smallest ring. Every cycle, a behavioural model in the bench predicts the fetch address, the response readiness and the completion fields. This happens while ready and response latency are throttled.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int ELEM_W   = 128;
  localparam int ELEM_SH  = 4;
  localparam int CHAIN_BT = 0;

  typedef struct packed {
    logic [31:0] rsvd;
    logic [15:0] ctrl;
    logic [15:0] len;
    logic [63:0] buf_addr;
  } tdc_elem_t;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_REQ  = 2'd1,
    W_RSP  = 2'd2,
    W_CPL  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/tdc_ctx_bank.sv
module tdc_ctx_bank #(
  parameter int NCH = 4,
  parameter int IW  = 8,
  parameter int AW  = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CHW-1:0]           cfg_ch,
  input  logic [AW-1:0]            cfg_base,
  input  logic [IW-1:0]            cfg_size,
  input  logic                     db_valid,
  input  logic [CHW-1:0]           db_ch,
  input  logic [IW-1:0]            db_wp,
  input  logic                     adv,
  input  logic [CHW-1:0]           adv_ch,
  output logic [NCH-1:0][AW-1:0]   base_a,
  output logic [NCH-1:0][IW-1:0]   rp_a,
  output logic [NCH-1:0][IW-1:0]   wp_a,
  output logic [NCH-1:0]           nonempty
);
  logic [NCH-1:0][IW-1:0] size_a;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_cfg, hit_db, hit_adv;
    logic [IW-1:0] rp_inc;
    assign hit_cfg = cfg_we   && (cfg_ch == CHW'(i));
    assign hit_db  = db_valid && (db_ch  == CHW'(i));
    assign hit_adv = adv      && (adv_ch == CHW'(i));
    assign rp_inc  = (rp_a[i] == size_a[i] - IW'(1)) ? '0 : rp_a[i] + IW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_a[i] <= '0;
        size_a[i] <= IW'(2);
        rp_a[i]   <= '0;
        wp_a[i]   <= '0;
      end else if (hit_cfg) begin
        base_a[i] <= cfg_base;
        size_a[i] <= cfg_size;
        rp_a[i]   <= '0;
        wp_a[i]   <= '0;
      end else begin
        if (hit_adv) rp_a[i] <= rp_inc;
        if (hit_db)  wp_a[i] <= db_wp;
      end
    end

    assign nonempty[i] = (rp_a[i] != wp_a[i]);
  end
endmodule

// File: rtl/tdc_rr_arb.sv
module tdc_rr_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           take,
  output logic           any,
  output logic [CHW-1:0] gnt
);
  logic [CHW-1:0] last_q;

  always_comb begin
    any = 1'b0;
    gnt = '0;
    for (int off = 1; off <= NCH; off++) begin
      int k;
      k = int'(last_q) + off;
      if (k >= NCH) k = k - NCH;
      if (!any && req[k]) begin
        any = 1'b1;
        gnt = CHW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= CHW'(NCH - 1);
    else if (take) last_q <= gnt;
  end
endmodule

// File: rtl/tdc_walker.sv
module tdc_walker
  import tdc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 8,
  parameter int AW  = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = 16 + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_pend,
  input  logic [CHW-1:0]    gnt_ch,
  output logic              take,
  output logic [CHW-1:0]    ch_o,
  input  logic [AW-1:0]     cur_base,
  input  logic [IW-1:0]     cur_rp,
  input  logic [IW-1:0]     cur_wp,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [ELEM_W-1:0] rsp_data,
  output logic              adv,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [IW-1:0]     cpl_elems,
  output logic [BW-1:0]     cpl_bytes
);
  walk_state_e st_q;
  logic [CHW-1:0] ch_q;
  logic [IW-1:0]  cnt_q;
  logic [BW-1:0]  bytes_q;
  tdc_elem_t      elem;
  logic           chain;

  assign elem  = tdc_elem_t'(rsp_data);
  assign chain = elem.ctrl[CHAIN_BT];

  assign take      = (st_q == W_IDLE) && any_pend;
  assign ch_o      = ch_q;
  assign req_valid = (st_q == W_REQ) && (cur_rp != cur_wp);
  assign req_addr  = cur_base + AW'({cur_rp, {ELEM_SH{1'b0}}});
  assign rsp_ready = (st_q == W_RSP);
  assign adv       = (st_q == W_RSP) && rsp_valid;
  assign cpl_valid = (st_q == W_CPL);
  assign cpl_elems = cnt_q;
  assign cpl_bytes = bytes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      ch_q    <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (any_pend) begin
          ch_q    <= gnt_ch;
          cnt_q   <= '0;
          bytes_q <= '0;
          st_q    <= W_REQ;
        end
        W_REQ: if (req_valid && req_ready) st_q <= W_RSP;
        W_RSP: if (rsp_valid) begin
          cnt_q   <= cnt_q + IW'(1);
          bytes_q <= bytes_q + BW'(elem.len);
          st_q    <= chain ? W_REQ : W_CPL;
        end
        W_CPL: if (cpl_ready) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdc_ring_consumer.sv
module tdc_ring_consumer
  import tdc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 8,
  parameter int AW  = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = 16 + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [AW-1:0]     cfg_base,
  input  logic [IW-1:0]     cfg_size,
  input  logic              db_valid,
  input  logic [CHW-1:0]    db_ch,
  input  logic [IW-1:0]     db_wp,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [ELEM_W-1:0] rd_rsp_data,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [CHW-1:0]    cpl_ch,
  output logic [IW-1:0]     cpl_elems,
  output logic [BW-1:0]     cpl_bytes,
  output logic [IW-1:0]     cpl_next_rp
);
  logic [NCH-1:0][AW-1:0] base_a;
  logic [NCH-1:0][IW-1:0] rp_a, wp_a;
  logic [NCH-1:0]         nonempty;
  logic                   any_pend, take, adv;
  logic [CHW-1:0]         gnt, ch_sel;

  tdc_ctx_bank #(.NCH(NCH), .IW(IW), .AW(AW)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .db_valid(db_valid), .db_ch(db_ch), .db_wp(db_wp),
    .adv(adv), .adv_ch(ch_sel),
    .base_a(base_a), .rp_a(rp_a), .wp_a(wp_a), .nonempty(nonempty)
  );

  tdc_rr_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(nonempty), .take(take),
    .any(any_pend), .gnt(gnt)
  );

  tdc_walker #(.NCH(NCH), .IW(IW), .AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .any_pend(any_pend), .gnt_ch(gnt), .take(take), .ch_o(ch_sel),
    .cur_base(base_a[ch_sel]), .cur_rp(rp_a[ch_sel]), .cur_wp(wp_a[ch_sel]),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready), .rsp_data(rd_rsp_data),
    .adv(adv),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_elems(cpl_elems), .cpl_bytes(cpl_bytes)
  );

  assign cpl_ch      = ch_sel;
  assign cpl_next_rp = rp_a[ch_sel];
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int NCH = 4,
  parameter int IW  = 8,
  parameter int AW  = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = 16 + IW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_req_valid,
  input logic           rd_req_ready,
  input logic [AW-1:0]  rd_req_addr,
  input logic           rd_rsp_valid,
  input logic           rd_rsp_ready,
  input logic           cpl_valid,
  input logic           cpl_ready,
  input logic [CHW-1:0] cpl_ch,
  input logic [IW-1:0]  cpl_elems,
  input logic [BW-1:0]  cpl_bytes,
  input logic [IW-1:0]  cpl_next_rp
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_cpl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_ch) && $stable(cpl_elems)
      && $stable(cpl_bytes) && $stable(cpl_next_rp));

  p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid && rd_rsp_ready);

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  p_cpl_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_valid) |-> $past(rd_rsp_valid && rd_rsp_ready));

  p_nofetch_in_cpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !rd_req_valid && !rd_rsp_ready);
endmodule

bind tdc_ring_consumer tdc_checker #(.NCH(NCH), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_ch(cpl_ch),
  .cpl_elems(cpl_elems), .cpl_bytes(cpl_bytes), .cpl_next_rp(cpl_next_rp)
);

// File: tb/sim_tdc_ring_consumer.sv
`timescale 1ns/1ps
module sim_tdc_ring_consumer;
  localparam int NCH = 4, IW = 8, AW = 64, CHW = 2, BW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_we = 0; logic [CHW-1:0] cfg_ch = 0; logic [AW-1:0] cfg_base = 0; logic [IW-1:0] cfg_size = 0;
  logic db_valid = 0; logic [CHW-1:0] db_ch = 0; logic [IW-1:0] db_wp = 0;
  logic rd_req_valid, rd_req_ready = 1, rd_rsp_valid = 0, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr; logic [127:0] rd_rsp_data = '0;
  logic cpl_valid, cpl_ready = 1; logic [CHW-1:0] cpl_ch;
  logic [IW-1:0] cpl_elems, cpl_next_rp; logic [BW-1:0] cpl_bytes;

  tdc_ring_consumer #(.NCH(NCH), .IW(IW), .AW(AW)) u0 (.*);

  int errors = 0, checks = 0, cyc = 0, lat = 0, bp = 0;
  int reqv_cnt = 0, req_stall = 0, cpl_stall = 0;
  bit chain_m [4][8];
  logic [63:0] pq [$];
  int wcnt = 0;
  int rec_ch [$], rec_el [$], rec_by [$], rec_rp [$];

  // behavioural reference model
  int mst = 0, mch = 0, mlast = 3, mcnt = 0, mby = 0;
  int mrp [4], mwp [4], msize [4];
  logic [63:0] mbase [4];

  function automatic logic [63:0] base_of(int c); return 64'h0000_1234_0000_0000 + 64'(c) * 64'h1_0000; endfunction
  function automatic int len_of(int c, int s); return 'h40 + c*16 + s; endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mlast = 3;
      for (int i = 0; i < 4; i++) begin mrp[i] = 0; mwp[i] = 0; msize[i] = 2; mbase[i] = 0; end
    end else begin
      cyc++;
      if (rd_req_valid) reqv_cnt++;
      if (rd_req_valid && !rd_req_ready) req_stall++;
      if (cpl_valid && !cpl_ready) cpl_stall++;
      if (rd_req_valid && rd_req_ready) pq.push_back(rd_req_addr);
      if (rd_rsp_valid && rd_rsp_ready) begin void'(pq.pop_front()); wcnt = 0; end
      if (cpl_valid && cpl_ready) begin
        rec_ch.push_back(int'(cpl_ch)); rec_el.push_back(int'(cpl_elems));
        rec_by.push_back(int'(cpl_bytes)); rec_rp.push_back(int'(cpl_next_rp));
      end
      case (mst)
        0: for (int off = 1; off <= 4; off++) begin
             int k; k = (mlast + off) % 4;
             if (mst == 0 && mrp[k] != mwp[k]) begin mst = 1; mch = k; mlast = k; mcnt = 0; mby = 0; end
           end
        1: if (mrp[mch] != mwp[mch] && rd_req_ready) mst = 2;
        2: if (rd_rsp_valid) begin
             mby += len_of(mch, mrp[mch]); mcnt++;
             mst = chain_m[mch][mrp[mch]] ? 1 : 3;
             mrp[mch] = (mrp[mch] + 1) % msize[mch];
           end
        3: if (cpl_ready) mst = 0;
        default: mst = 0;
      endcase
      if (cfg_we) begin mbase[cfg_ch] = cfg_base; msize[cfg_ch] = int'(cfg_size); mrp[cfg_ch] = 0; mwp[cfg_ch] = 0; end
      if (db_valid) mwp[db_ch] = int'(db_wp);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ev; ev = (mst == 1) && (mrp[mch] != mwp[mch]);
      chk(rd_req_valid == ev, "R3 req_valid", rd_req_valid, ev);
      if (ev) chk(rd_req_addr == mbase[mch] + 64'(mrp[mch]) * 16, "R3 req_addr", rd_req_addr, mbase[mch] + 64'(mrp[mch]) * 16);
      chk(rd_rsp_ready == (mst == 2), "R11 rsp_ready", rd_rsp_ready, mst == 2);
      chk(cpl_valid == (mst == 3), "R7 cpl_valid", cpl_valid, mst == 3);
      if (mst == 3) begin
        chk(int'(cpl_ch) == mch, "R7 cpl_ch", cpl_ch, mch);
        chk(int'(cpl_elems) == mcnt, "R7 cpl_elems", cpl_elems, mcnt);
        chk(int'(cpl_bytes) == mby, "R7 cpl_bytes", cpl_bytes, mby);
        chk(int'(cpl_next_rp) == mrp[mch], "R5 cpl_next_rp", cpl_next_rp, mrp[mch]);
      end
      if (pq.size() > 0) wcnt++;
    end
    rd_req_ready = bp ? (cyc % 3 == 2) : 1'b1;
    cpl_ready    = bp ? (cyc % 4 == 3) : 1'b1;
    if (pq.size() > 0 && wcnt > lat) begin
      logic [63:0] a; int c, s;
      a = pq[0]; c = int'((a >> 16) & 3); s = int'((a - base_of(c)) >> 4);
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = {32'h0, 15'h0, chain_m[c][s], 16'(len_of(c, s)), a ^ 64'hA5A5};
    end else begin
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = '0;
    end
  end

  task automatic cfg(input int c, input int sz);
    @(negedge clk); cfg_we = 1; cfg_ch = CHW'(c); cfg_base = base_of(c); cfg_size = IW'(sz);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic ring(input int c, input int wp);
    @(negedge clk); db_valid = 1; db_ch = CHW'(c); db_wp = IW'(wp);
    @(negedge clk); db_valid = 0;
  endtask
  task automatic cpl_is(input int i, input int c, input int el, input int by, input int rp, input string tag);
    if (rec_ch.size() <= i) begin chk(0, {tag, " missing completion"}, rec_ch.size(), i + 1); return; end
    chk(rec_ch[i] == c,  {tag, " ch"},    rec_ch[i], c);
    chk(rec_el[i] == el, {tag, " elems"}, rec_el[i], el);
    chk(rec_by[i] == by, {tag, " bytes"}, rec_by[i], by);
    chk(rec_rp[i] == rp, {tag, " rp"},    rec_rp[i], rp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && !rd_rsp_ready && !cpl_valid, "R1 reset outputs", {rd_req_valid, rd_rsp_ready, cpl_valid}, 0);
    rst_n = 1;
    for (int c = 0; c < 3; c++) cfg(c, 8);
    cfg(3, 4);
    repeat (10) @(negedge clk);
    chk(reqv_cnt == 0 && rec_ch.size() == 0, "R2 empty after config", reqv_cnt, 0);
    // single element
    chain_m[0][0] = 0; ring(0, 1); repeat (30) @(negedge clk);
    cpl_is(0, 0, 1, 'h40, 1, "R3");
    // chained descriptor of three elements
    chain_m[1][0] = 1; chain_m[1][1] = 1; chain_m[1][2] = 0; ring(1, 3); repeat (40) @(negedge clk);
    cpl_is(1, 1, 3, 'hF3, 3, "R6");
    // empty doorbell
    reqv_cnt = 0; ring(2, 0); repeat (20) @(negedge clk);
    chk(reqv_cnt == 0 && rec_ch.size() == 2, "R4 empty doorbell ignored", reqv_cnt, 0);
    // round robin
    chain_m[0][1] = 0; chain_m[2][0] = 0; chain_m[3][0] = 0;
    ring(0, 2); ring(3, 1); ring(2, 1); repeat (50) @(negedge clk);
    cpl_is(2, 0, 1, 'h41, 2, "R8"); cpl_is(3, 2, 1, 'h60, 1, "R8"); cpl_is(4, 3, 1, 'h70, 1, "R8");
    // full ring with wrap
    chain_m[3][1] = 0; chain_m[3][2] = 0; chain_m[3][3] = 0; ring(3, 0); repeat (50) @(negedge clk);
    cpl_is(5, 3, 1, 'h71, 2, "R5"); cpl_is(6, 3, 1, 'h72, 3, "R5"); cpl_is(7, 3, 1, 'h73, 0, "R5");
    ring(3, 1); repeat (20) @(negedge clk);
    cpl_is(8, 3, 1, 'h70, 1, "R5");
    // chain runs past written work
    chain_m[1][3] = 1; chain_m[1][4] = 0; ring(1, 4); repeat (15) @(negedge clk);
    reqv_cnt = 0; repeat (20) @(negedge clk);
    chk(reqv_cnt == 0 && rec_ch.size() == 9, "R9 stall without request", reqv_cnt, 0);
    ring(1, 5); repeat (30) @(negedge clk);
    cpl_is(9, 1, 2, 'hA7, 5, "R9");
    // back-pressure and latency
    bp = 1; lat = 3; req_stall = 0; cpl_stall = 0;
    chain_m[0][2] = 1; chain_m[0][3] = 1; chain_m[0][4] = 0; chain_m[2][1] = 0;
    ring(0, 5); ring(2, 2); repeat (150) @(negedge clk);
    cpl_is(10, 0, 3, 'hC9, 5, "R10"); cpl_is(11, 2, 1, 'h61, 2, "R10");
    chk(req_stall > 0 && cpl_stall > 0, "R10 stalls exercised", req_stall, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule